// File: doc/BRIEF.md
# SPI Control-Status Register Unit

This unit is the processor-facing side of a byte-wide SPI peripheral. Software reaches it over a small register bus with an address, a read strobe, a write strobe and write data, and it reads data back combinationally. There are three registers: control, control/status and data. A compact 8-bit shift engine sits behind the registers so that the unit can be exercised on its own. As master, the engine produces its own serial clock from the system clock with a fixed divide-by-four. As slave, it follows an external serial clock. Both roles use SPI mode 0 and shift MSB first.

Four status flags report the state of the link: transfer complete, write collision, overrun and mode fault. Each flag sets on a hardware event. It clears only through a defined sequence of register accesses, so software cannot lose an event it has not yet seen. Received bytes go to a receive buffer that is separate from the shift register, and reads of the data register return that buffer. Data writes are locked out while an unacknowledged transfer-complete is pending. Slave select can come from the pin or from a software bit. The serial data output can be disabled. One interrupt line summarises the flags that need attention.

Top module: `spi_csr_unit`

## Requirements
- R1: After reset, the control register and the control/status register both read 00h, and irq_o is low.
- R2: Control/status register bits, from MSB to LSB: done, wcol, ovr, modf, a bit that always reads 0, odis, ssm, ssi. A write to this register changes only odis, ssm and ssi. Control register bits: 7 = interrupt enable, 6 = peripheral enable, 4 = master; all other bits read 0. Register addresses: 0 = control, 1 = control/status, 2 = data.
- R3: With the peripheral enabled as master, a data write starts a transfer. The transfer shifts 8 bits MSB first on mosi_o, with eight rising edges on sck_o at four system clocks per bit, and samples miso_i on each rising edge. Once the transfer completes, done is set and a data read returns the received byte.
- R4: done clears only when a control/status read is followed by a read or write of the data register. A data access with no status read before it leaves done set.
- R5: While done is set and the control/status register has not been read since, every data write is ignored and starts no transfer. After the status read, a data write is accepted.
- R6: A data write while a transfer is in progress sets wcol. The transfer in flight is not changed. wcol clears through the same status-read-then-data-access sequence as done.
- R7: A byte that completes while done is still set sets ovr. The byte already in the receive buffer is kept and the new byte is dropped. A control/status read clears ovr.
- R8: When the internal slave select is low in master mode, modf is set, and peripheral enable and master are forced to 0. modf clears only when the control/status register is read while modf is set and the control register is then written.
- R9: With ssm = 1, the internal slave select follows ssi (0 = selected) and the ss_n_i pin is ignored. With ssm = 0, ss_n_i drives it.
- R10: With odis = 1, mosi_oe_o and miso_oe_o are low and mosi_o and miso_o stay 0. With odis = 0, mosi_oe_o is high when the peripheral is enabled as master.
- R11: irq_o is high exactly when interrupt enable is set and any of done, ovr or modf is set.
- R12: Enabled as slave and selected, the unit samples mosi_i on rising edges of sck_i and shifts on falling edges. It drives the byte last written to the data register onto miso_o, MSB first, and sets done after 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register select: 0 control, 1 control/status, 2 data |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| sck_o | output | 1 | Serial clock driven as master |
| mosi_o | output | 1 | Serial data out as master |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| sck_i | input | 1 | Serial clock received as slave |
| mosi_i | input | 1 | Serial data in as slave |
| miso_i | input | 1 | Serial data in as master |
| miso_o | output | 1 | Serial data out as slave |
| miso_oe_o | output | 1 | Output enable for miso_o |
| ss_n_i | input | 1 | Slave-select pin, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the access sequences that clear the flags. It reads the data register before any status read; a design that cleared done on any data access would report a clear status afterwards. It writes data while done is pending and again while a transfer runs; a design without the lockout would start a second transfer, and one that accepted the colliding byte would change the bits on mosi_o. It completes two slave bytes with no acknowledge between them, to catch a design that overwrites the buffered byte on overrun. It also writes the control register before and after the status read on a mode fault, to catch a design that drops modf on any control write.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_STAT  = 2'd1,
    RA_DATA  = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;

  // control register field positions
  localparam int CB_IE  = 7;
  localparam int CB_EN  = 6;
  localparam int CB_MST = 4;

  // control/status register field positions
  localparam int SB_ODIS = 2;
  localparam int SB_SSM  = 1;
  localparam int SB_SSI  = 0;
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int W      = 8,
  parameter int DIV    = 4,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         master,
  input  logic         sel,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         sck_in,
  input  logic         sdi,
  output logic         busy,
  output logic         xfer_done,
  output logic [W-1:0] rx_word,
  output logic         sdo,
  output logic         sck_out
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int BW   = $clog2(W);

  logic [W-1:0]      sh_q, sh_d;
  logic              smp_q, smp_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [CW-1:0]     div_q, div_d;
  logic              mact_q, mact_d;
  logic              sck_q, sck_d;
  logic [SYNC_N-1:0] sck_sync_q;
  logic              sck_prev_q;

  logic slv_on, sck_s, m_rise, m_fall, rise, fall, last;

  always_comb begin
    slv_on  = en & ~master & sel;
    sck_s   = sck_sync_q[SYNC_N-1];
    m_rise  = mact_q & (div_q == CW'(HALF - 1));
    m_fall  = mact_q & (div_q == CW'(DIV - 1));
    rise    = m_rise | (slv_on & sck_s & ~sck_prev_q);
    fall    = m_fall | (slv_on & ~sck_s & sck_prev_q);
    last    = fall & (bit_q == BW'(W - 1));
    rx_word = {sh_q[W-2:0], smp_q};
  end

  always_comb begin
    sh_d   = sh_q;
    smp_d  = smp_q;
    bit_d  = bit_q;
    div_d  = div_q;
    mact_d = mact_q;
    sck_d  = sck_q;
    if (rise) smp_d = sdi;
    if (load)      sh_d = load_data;
    else if (fall) sh_d = rx_word;
    if (fall) bit_d = bit_q + BW'(1);
    if (last) bit_d = '0;
    if (mact_q) div_d = (div_q == CW'(DIV - 1)) ? '0 : div_q + CW'(1);
    if (m_rise) sck_d = 1'b1;
    if (m_fall) sck_d = 1'b0;
    if (last & master) mact_d = 1'b0;
    if (load & master & en) begin
      mact_d = 1'b1;
      div_d  = '0;
      bit_d  = '0;
      sck_d  = 1'b0;
    end
    if (~en | ~master) begin
      mact_d = 1'b0;
      div_d  = '0;
      sck_d  = 1'b0;
    end
    if (~en | (~master & ~sel)) bit_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      smp_q      <= 1'b0;
      bit_q      <= '0;
      div_q      <= '0;
      mact_q     <= 1'b0;
      sck_q      <= 1'b0;
      sck_sync_q <= '0;
      sck_prev_q <= 1'b0;
    end else begin
      sh_q       <= sh_d;
      smp_q      <= smp_d;
      bit_q      <= bit_d;
      div_q      <= div_d;
      mact_q     <= mact_d;
      sck_q      <= sck_d;
      sck_sync_q <= {sck_sync_q[SYNC_N-2:0], sck_in};
      sck_prev_q <= sck_s;
    end
  end

  assign busy      = mact_q | (bit_q != '0);
  assign xfer_done = last;
  assign sdo       = sh_q[W-1];
  assign sck_out   = sck_q;
endmodule

// File: rtl/spi_csr_flags.sv
module spi_csr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic data_wr,
  input  logic ctrl_wr,
  input  logic busy,
  input  logic xfer_done,
  input  logic modf_cond,
  output logic done,
  output logic wcol,
  output logic ovr,
  output logic modf,
  output logic seen,
  output logic data_ld,
  output logic buf_ld
);
  logic done_d, wcol_d, ovr_d, modf_d, seen_d, marm_q, marm_d;
  logic seq_clr, done_left;

  always_comb begin
    seq_clr   = seen & (data_rd | data_wr);
    done_left = done & ~seq_clr;
    data_ld   = data_wr & ~busy & (~done | seen);
    buf_ld    = xfer_done & ~done_left;

    seen_d = seen;
    if (stat_rd) seen_d = 1'b1;
    if (data_rd | data_wr) seen_d = 1'b0;

    done_d = xfer_done ? 1'b1 : done_left;

    wcol_d = wcol;
    if (seq_clr) wcol_d = 1'b0;
    if (data_wr & busy) wcol_d = 1'b1;

    ovr_d = ovr;
    if (stat_rd) ovr_d = 1'b0;
    if (xfer_done & done_left) ovr_d = 1'b1;

    marm_d = marm_q;
    if (stat_rd & modf) marm_d = 1'b1;
    if (ctrl_wr) marm_d = 1'b0;

    modf_d = modf;
    if (ctrl_wr & marm_q) modf_d = 1'b0;
    if (modf_cond) modf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      wcol   <= 1'b0;
      ovr    <= 1'b0;
      modf   <= 1'b0;
      seen   <= 1'b0;
      marm_q <= 1'b0;
    end else begin
      done   <= done_d;
      wcol   <= wcol_d;
      ovr    <= ovr_d;
      modf   <= modf_d;
      seen   <= seen_d;
      marm_q <= marm_d;
    end
  end
endmodule

// File: rtl/spi_csr_unit.sv
module spi_csr_unit
  import spi_csr_pkg::*;
#(
  parameter int SHIFT_DIV = 4,
  parameter int SYNC_N    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic             ss_n_i,
  output logic             irq_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_l;
  logic [SYNC_N-1:0] ss_pipe_q;

  logic ie_q, ie_d, en_q, en_d, mst_q, mst_d;
  logic odis_q, odis_d, ssm_q, ssm_d, ssi_q, ssi_d;
  logic [REG_W-1:0] rx_buf_q, rx_buf_d;

  logic ctrl_wr, stat_wr, data_wr, stat_rd, data_rd;
  logic ss_int_n, sel, modf_cond;
  logic done, wcol, ovr, modf, seen, data_ld, buf_ld;
  logic busy, xfer_done, sdo, sdi;
  logic [REG_W-1:0] rx_word;
  logic unused_wd;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_l = rst_pipe_q[1];

  always_comb begin
    ctrl_wr   = reg_wr & (reg_addr == RA_CTRL);
    stat_wr   = reg_wr & (reg_addr == RA_STAT);
    data_wr   = reg_wr & (reg_addr == RA_DATA);
    stat_rd   = reg_rd & (reg_addr == RA_STAT);
    data_rd   = reg_rd & (reg_addr == RA_DATA);
    ss_int_n  = ssm_q ? ssi_q : ss_pipe_q[SYNC_N-1];
    sel       = ~ss_int_n;
    modf_cond = en_q & mst_q & ~ss_int_n;
    sdi       = mst_q ? miso_i : mosi_i;
  end

  always_comb begin
    ie_d   = ie_q;
    en_d   = en_q;
    mst_d  = mst_q;
    odis_d = odis_q;
    ssm_d  = ssm_q;
    ssi_d  = ssi_q;
    if (ctrl_wr) begin
      ie_d  = reg_wdata[CB_IE];
      en_d  = reg_wdata[CB_EN];
      mst_d = reg_wdata[CB_MST];
    end
    if (modf_cond) begin
      en_d  = 1'b0;
      mst_d = 1'b0;
    end
    if (stat_wr) begin
      odis_d = reg_wdata[SB_ODIS];
      ssm_d  = reg_wdata[SB_SSM];
      ssi_d  = reg_wdata[SB_SSI];
    end
    rx_buf_d = buf_ld ? rx_word : rx_buf_q;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      ie_q      <= 1'b0;
      en_q      <= 1'b0;
      mst_q     <= 1'b0;
      odis_q    <= 1'b0;
      ssm_q     <= 1'b0;
      ssi_q     <= 1'b0;
      rx_buf_q  <= '0;
      ss_pipe_q <= '1;
    end else begin
      ie_q      <= ie_d;
      en_q      <= en_d;
      mst_q     <= mst_d;
      odis_q    <= odis_d;
      ssm_q     <= ssm_d;
      ssi_q     <= ssi_d;
      rx_buf_q  <= rx_buf_d;
      ss_pipe_q <= {ss_pipe_q[SYNC_N-2:0], ss_n_i};
    end
  end

  spi_csr_flags flags_i (
    .clk       (clk),
    .rst_n     (rst_l),
    .stat_rd   (stat_rd),
    .data_rd   (data_rd),
    .data_wr   (data_wr),
    .ctrl_wr   (ctrl_wr),
    .busy      (busy),
    .xfer_done (xfer_done),
    .modf_cond (modf_cond),
    .done      (done),
    .wcol      (wcol),
    .ovr       (ovr),
    .modf      (modf),
    .seen      (seen),
    .data_ld   (data_ld),
    .buf_ld    (buf_ld)
  );

  spi_shift_engine #(.W(REG_W), .DIV(SHIFT_DIV), .SYNC_N(SYNC_N)) eng_i (
    .clk       (clk),
    .rst_n     (rst_l),
    .en        (en_q),
    .master    (mst_q),
    .sel       (sel),
    .load      (data_ld),
    .load_data (reg_wdata),
    .sck_in    (sck_i),
    .sdi       (sdi),
    .busy      (busy),
    .xfer_done (xfer_done),
    .rx_word   (rx_word),
    .sdo       (sdo),
    .sck_out   (sck_o)
  );

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {ie_q, en_q, 1'b0, mst_q, 4'b0000};
      RA_STAT: reg_rdata = {done, wcol, ovr, modf, 1'b0, odis_q, ssm_q, ssi_q};
      RA_DATA: reg_rdata = rx_buf_q;
      default: reg_rdata = '0;
    endcase
  end

  assign mosi_oe_o = en_q & mst_q & ~odis_q;
  assign miso_oe_o = en_q & ~mst_q & sel & ~odis_q;
  assign mosi_o    = mosi_oe_o & sdo;
  assign miso_o    = miso_oe_o & sdo;
  assign irq_o     = ie_q & (done | ovr | modf);
  assign unused_wd = ^{reg_wdata[5], reg_wdata[3]};
endmodule

// File: rtl/spi_csr_checker.sv
module spi_csr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic       data_rd,
  input logic       data_wr,
  input logic       busy,
  input logic       xfer_done,
  input logic       done,
  input logic       wcol,
  input logic       seen,
  input logic       modf,
  input logic       en,
  input logic       mst,
  input logic [7:0] rx_buf
);
  AST_DONE_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(seen && (data_rd || data_wr) && !stat_rd)); // R4

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && done && !seen && !busy) |=> (done && !busy)); // R5

  AST_WCOL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol); // R6

  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && done && !(seen && (data_rd || data_wr))) |=> $stable(rx_buf)); // R7

  AST_MODF_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> (!en && !mst)); // R8
endmodule

bind spi_csr_unit spi_csr_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_l),
  .stat_rd   (stat_rd),
  .data_rd   (data_rd),
  .data_wr   (data_wr),
  .busy      (busy),
  .xfer_done (xfer_done),
  .done      (done),
  .wcol      (wcol),
  .seen      (seen),
  .modf      (modf),
  .en        (en_q),
  .mst       (mst_q),
  .rx_buf    (rx_buf_q)
);

// File: tb/spi_csr_unit_tb_top.sv
module spi_csr_unit_tb_top;
  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 150000;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic clk, rst_n, reg_rd, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sck_o, mosi_o, mosi_oe_o, sck_i, mosi_i, miso_i, miso_o, miso_oe_o, ss_n_i, irq_o;

  int n_chk, n_bad, cyc;
  bit fin;
  logic [7:0] bm, mcap, rd;
  int mcnt;

  spi_csr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o), .mosi_o(mosi_o),
    .mosi_oe_o(mosi_oe_o), .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .ss_n_i(ss_n_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // remote slave model for master transfers
  always @(negedge sck_o) bm <= {bm[6:0], 1'b0};
  assign miso_i = bm[7];
  always @(posedge sck_o) begin
    mcap <= {mcap[6:0], mosi_o};
    mcnt <= mcnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !fin) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: all requirements, actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (got !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #(CLK_P/4);
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic m_start(input logic [7:0] tx, input logic [7:0] remote);
    @(negedge clk);
    bm <= remote;
    mcnt <= 0;
    bus_wr(A_DATA, tx);
  endtask

  task automatic s_send(input logic [7:0] b, output logic [7:0] cap);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = b[i];
      idle(6);
      cap[i] = miso_o;
      sck_i = 1'b1;
      idle(6);
      sck_i = 1'b0;
    end
    idle(8);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(4);
    bus_rd(A_STAT, rd); check("R1 status after reset", rd, 8'h00);
    bus_rd(A_CTRL, rd); check("R1 control after reset", rd, 8'h00);
    check("R1 irq after reset", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_layout;
    bus_wr(A_STAT, 8'hFF);
    bus_rd(A_STAT, rd); check("R2 only low config bits writable", rd, 8'h07);
    bus_wr(A_STAT, 8'h00);
    bus_wr(A_CTRL, 8'hFF);
    bus_rd(A_CTRL, rd); check("R2 control field mask", rd, 8'hD0);
    bus_wr(A_CTRL, 8'h00);
  endtask

  task automatic t_master;
    bus_wr(A_CTRL, 8'h50);
    m_start(8'hA5, 8'h3C); idle(40);
    check("R3 sck rising edges", 8'(mcnt), 8'd8);
    check("R3 bits on mosi", mcap, 8'hA5);
    bus_rd(A_STAT, rd); check("R3 done set", rd, 8'h80);
    bus_rd(A_DATA, rd); check("R3 received byte", rd, 8'h3C);
    bus_rd(A_STAT, rd); check("R4 sequence clears done", rd, 8'h00);
    m_start(8'h0F, 8'hE1); idle(40);
    bus_rd(A_DATA, rd); check("R4 data read returns buffer", rd, 8'hE1);
    bus_rd(A_STAT, rd); check("R4 data read without status read keeps done", rd, 8'h80);
    bus_rd(A_DATA, rd);
  endtask

  task automatic t_lockout;
    m_start(8'h11, 8'h00); idle(40);
    @(negedge clk); mcnt <= 0;
    bus_wr(A_DATA, 8'h22); idle(40);
    check("R5 locked write starts nothing", 8'(mcnt), 8'd0);
    bus_rd(A_STAT, rd); check("R5 done still pending", rd, 8'h80);
    m_start(8'h33, 8'h00); idle(40);
    check("R5 write accepted after status read", mcap, 8'h33);
    bus_rd(A_STAT, rd); bus_rd(A_DATA, rd);
  endtask

  task automatic t_wcol;
    m_start(8'h5A, 8'h00); idle(5);
    bus_wr(A_DATA, 8'hFF); idle(40);
    check("R6 transfer in flight unchanged", mcap, 8'h5A);
    check("R6 single transfer", 8'(mcnt), 8'd8);
    bus_rd(A_STAT, rd); check("R6 wcol with done", rd, 8'hC0);
    bus_rd(A_DATA, rd);
    bus_rd(A_STAT, rd); check("R6 wcol cleared by sequence", rd, 8'h00);
  endtask

  task automatic t_irq;
    bus_wr(A_CTRL, 8'hD0);
    m_start(8'h77, 8'h88); idle(40);
    check("R11 irq on done", {7'b0, irq_o}, 8'h01);
    bus_rd(A_STAT, rd);
    bus_rd(A_DATA, rd); check("R3 byte from remote", rd, 8'h88);
    check("R11 irq drops after clear", {7'b0, irq_o}, 8'h00);
    bus_wr(A_CTRL, 8'h50);
  endtask

  task automatic t_odis;
    bus_wr(A_STAT, 8'h04); idle(1);
    check("R10 mosi output disabled", {7'b0, mosi_oe_o}, 8'h00);
    m_start(8'hFF, 8'h00); idle(40);
    check("R10 mosi held low", mcap, 8'h00);
    bus_rd(A_STAT, rd); bus_rd(A_DATA, rd);
    bus_wr(A_STAT, 8'h00); idle(1);
    check("R10 mosi output re-enabled", {7'b0, mosi_oe_o}, 8'h01);
  endtask

  task automatic t_ssm;
    bus_wr(A_CTRL, 8'h00);
    ss_n_i = 1'b0;
    bus_wr(A_STAT, 8'h03);
    bus_wr(A_CTRL, 8'h50); idle(4);
    bus_rd(A_CTRL, rd); check("R9 pin ignored under ssm", rd, 8'h50);
    bus_wr(A_STAT, 8'h02); idle(2);
    bus_rd(A_STAT, rd); check("R9 ssi low gives fault", rd, 8'h12);
    bus_rd(A_CTRL, rd); check("R9 master dropped", rd, 8'h00);
    bus_wr(A_CTRL, 8'h00);
    ss_n_i = 1'b1;
    bus_wr(A_STAT, 8'h00);
    bus_rd(A_STAT, rd); check("R9 clean after clear", rd, 8'h00);
  endtask

  task automatic t_modf;
    bus_wr(A_CTRL, 8'hD0);
    ss_n_i = 1'b0; idle(5);
    check("R11 irq on mode fault", {7'b0, irq_o}, 8'h01);
    bus_rd(A_CTRL, rd); check("R8 enable and master forced off", rd, 8'h80);
    bus_wr(A_CTRL, 8'h80);
    bus_rd(A_STAT, rd); check("R8 control write alone keeps modf", rd, 8'h10);
    ss_n_i = 1'b1;
    bus_wr(A_CTRL, 8'h00);
    bus_rd(A_STAT, rd); check("R8 read then control write clears", rd, 8'h00);
  endtask

  task automatic t_slave;
    logic [7:0] cap;
    ss_n_i = 1'b0;
    bus_wr(A_CTRL, 8'h40);
    bus_wr(A_DATA, 8'hC3); idle(2);
    check("R12 miso enabled when selected", {7'b0, miso_oe_o}, 8'h01);
    s_send(8'h96, cap);
    check("R12 byte on miso", cap, 8'hC3);
    bus_rd(A_STAT, rd); check("R12 done as slave", rd, 8'h80);
    bus_rd(A_DATA, rd); check("R12 byte from mosi", rd, 8'h96);
  endtask

  task automatic t_ovr;
    logic [7:0] cap;
    s_send(8'h11, cap);
    s_send(8'h22, cap);
    bus_rd(A_STAT, rd); check("R7 overrun flagged", rd, 8'hA0);
    bus_rd(A_DATA, rd); check("R7 first byte kept", rd, 8'h11);
    bus_rd(A_STAT, rd); check("R7 overrun cleared", rd, 8'h00);
    ss_n_i = 1'b1;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; fin = 1'b0;
    bm = 8'h00; mcap = 8'h00; mcnt = 0;
    rst_n = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    sck_i = 1'b0; mosi_i = 1'b0; ss_n_i = 1'b1;
    t_reset;
    t_layout;
    t_master;
    t_lockout;
    t_wcol;
    t_irq;
    t_odis;
    t_ssm;
    t_modf;
    t_slave;
    t_ovr;
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule